// File: doc/BRIEF.md
# In-System Programming Status Pins and Command Guard

This block sits next to the boundary-scan controller of a flash-based programmable device. The controller decodes configuration-mode commands and hands each one over as a single-cycle strobe. The block does four things with them:

- It decides which commands may reach the flash program/erase engine.
- It keeps a sticky failure flag.
- It drives two dedicated pins: a ready/busy status pin and an active-low error pin.
- It lets each pin be set up either as push-pull or as open-drain, so that several chained devices can share one wired-OR line.

Both pins work only after a configuration-enable command. While the device is secured, only a whole-array erase is allowed through. A whole-array erase lifts the lock. A sector erase is refused when it aims at a protected sector.

The command port is a plain strobe with no back-pressure. A command seen with `cmd_valid` high on a rising edge is always consumed in that cycle. It is either acted on, ignored, or refused. The engine start it may produce is a one-cycle pulse. The engine must treat that pulse as taken.

Top module: `isp_status_guard`

## Requirements
- R1: While configuration mode is off, every command except enable (code 1) is ignored: it starts no engine cycle and changes no state. Both pins are undriven (`stat_oe` and `err_oe` low, outputs low).
- R2: Enable (code 1) turns configuration mode on and captures `cmd_od`: bit 0 selects open-drain for the status pin, bit 1 selects it for the error pin. Disable (code 2) turns configuration mode off.
- R3: The status pin value is 1 when idle. It is 0 while `eng_busy` or `sec_wr_busy` is high. The pin follows these inputs one clock later.
- R4: In push-pull mode a pin has `oe`=1 and output equal to its value. In open-drain mode the output is always 0 and `oe` is the inverse of the value. Pin registers add one clock after the internal state.
- R5: A high `eng_fail`, or a refused command, sets the sticky error. The error pin value then stays 0 until it is released as R6 or R7 describe. If a failure and a release fall in the same cycle, the failure wins.
- R6: Clear (code 3), issued while configuration mode is on, releases the error.
- R7: A `chip_rst` pulse releases the error only while configuration mode is off, that is, after a disable. While configuration mode is on, `chip_rst` has no effect on the error.
- R8: While `locked` is high, program (4), sector erase (5) and verify (7) are refused.
- R9: Whole-array erase (6) is accepted even when the device is locked. From the next cycle on, `locked` is low until `rst_n` is asserted. `locked` equals `sec_cfg` before any whole-array erase.
- R10: A sector erase is refused when `sect_prot[cmd_sector]` is 1 or when the sector index is out of range.
- R11: An accepted flash command (codes 4 to 7) raises `eng_start` for exactly one cycle after the sampling edge. `eng_op` carries the code and `eng_sector` carries the sector. A refused command never raises `eng_start`.
- R12: While `rst_n` is low, configuration mode is off, the error is released, the erase history is cleared and `eng_start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 3 | Command code (0 none, 1 enable, 2 disable, 3 clear, 4 program, 5 sector erase, 6 whole-array erase, 7 verify) |
| cmd_sector | input | SW | Target sector index |
| cmd_od | input | 2 | Open-drain selects captured on enable (bit 0 status, bit 1 error) |
| sec_cfg | input | 1 | Security setting from configuration storage |
| sect_prot | input | NSECT | Per-sector erase-protect bits |
| eng_busy | input | 1 | Flash engine program/erase in progress |
| eng_fail | input | 1 | Flash engine failure pulse |
| sec_wr_busy | input | 1 | Secondary region write in progress |
| chip_rst | input | 1 | Device reset pulse |
| eng_start | output | 1 | Start pulse to the flash engine |
| eng_op | output | 3 | Operation code for the engine |
| eng_sector | output | SW | Sector for the engine |
| locked | output | 1 | Security lock in force |
| stat_o | output | 1 | Status pin output value |
| stat_oe | output | 1 | Status pin output enable |
| err_o | output | 1 | Error pin output value |
| err_oe | output | 1 | Error pin output enable |

## Verification
The hardest state to reach is an error raised during configuration mode and then carried across a disable. Only a `chip_rst` arriving after that disable may release it, and a re-enable without that pulse must still show the pin low. The bench builds each ordering from the ports in turn: fail then clear, fail then reset while enabled, fail then disable, reset and re-enable, and fail then disable and re-enable with no reset. It then sweeps every flash command against every sector, two protect patterns and both lock states, starting from a fresh reset each time so that a lock lifted by a whole-array erase cannot leak into the next case.

// File: rtl/isp_pkg.sv
package isp_pkg;
  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_ENABLE = 3'd1,
    CMD_DISABLE= 3'd2,
    CMD_CLEAR  = 3'd3,
    CMD_PROG   = 3'd4,
    CMD_ERSECT = 3'd5,
    CMD_ERALL  = 3'd6,
    CMD_VERIFY = 3'd7
  } isp_cmd_e;

  localparam int PIN_STAT = 0;
  localparam int PIN_ERR  = 1;
  localparam int NPIN     = 2;
endpackage

// File: rtl/isp_cmd_guard.sv
module isp_cmd_guard
  import isp_pkg::*;
#(
  parameter int NSECT = 8,
  localparam int SW = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic [SW-1:0]    cmd_sector,
  input  logic [NPIN-1:0]  cmd_od,
  input  logic             sec_cfg,
  input  logic [NSECT-1:0] sect_prot,
  output logic             isc_en,
  output logic [NPIN-1:0]  od_mode,
  output logic             locked,
  output logic             refuse_c,
  output logic             clear_c,
  output logic             eng_start,
  output logic [2:0]       eng_op,
  output logic [SW-1:0]    eng_sector
);
  isp_cmd_e cmd;
  logic     erased_q;
  logic     go_c;
  logic     sect_ok;

  assign cmd    = isp_cmd_e'(cmd_code);
  assign locked = sec_cfg & ~erased_q;

  always_comb begin
    sect_ok = 1'b0;
    if (32'(cmd_sector) < NSECT) sect_ok = ~sect_prot[cmd_sector];
  end

  always_comb begin
    go_c     = 1'b0;
    refuse_c = 1'b0;
    clear_c  = 1'b0;
    if (cmd_valid && isc_en) begin
      unique case (cmd)
        CMD_CLEAR:             clear_c = 1'b1;
        CMD_PROG, CMD_VERIFY:  if (locked) refuse_c = 1'b1; else go_c = 1'b1;
        CMD_ERSECT:            if (locked || !sect_ok) refuse_c = 1'b1; else go_c = 1'b1;
        CMD_ERALL:             go_c = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isc_en     <= 1'b0;
      od_mode    <= '0;
      erased_q   <= 1'b0;
      eng_start  <= 1'b0;
      eng_op     <= 3'd0;
      eng_sector <= '0;
    end else begin
      eng_start <= go_c;
      if (go_c) begin
        eng_op     <= cmd_code;
        eng_sector <= cmd_sector;
      end
      if (go_c && cmd == CMD_ERALL) erased_q <= 1'b1;
      if (cmd_valid && cmd == CMD_ENABLE) begin
        isc_en  <= 1'b1;
        od_mode <= cmd_od;
      end else if (cmd_valid && isc_en && cmd == CMD_DISABLE) begin
        isc_en <= 1'b0;
      end
    end
  end

  assert_locked_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && isc_en && locked && cmd != CMD_ERALL) |=> !eng_start);

  assert_prot_refused_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && isc_en && cmd == CMD_ERSECT && 32'(cmd_sector) < NSECT
     && sect_prot[cmd_sector]) |=> !eng_start);

  assert_idle_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !isc_en && cmd != CMD_ENABLE) |=> (!isc_en && !eng_start));

  assert_erall_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && isc_en && cmd == CMD_ERALL) |=> (!locked && eng_start));

  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && !(cmd_valid && isc_en)) |=> !eng_start);
endmodule

// File: rtl/isp_err_track.sv
module isp_err_track (
  input  logic clk,
  input  logic rst_n,
  input  logic fail,
  input  logic clr,
  input  logic chip_rst,
  input  logic isc_en,
  output logic err_q
);
  logic release_c;
  assign release_c = clr | (chip_rst & ~isc_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (fail)       err_q <= 1'b1;
    else if (release_c)  err_q <= 1'b0;
  end

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr && !chip_rst) |=> err_q);

  assert_fail_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> err_q);

  assert_rst_enabled_noeffect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && chip_rst && isc_en && !clr) |=> err_q);
endmodule

// File: rtl/isp_pin_drv.sv
module isp_pin_drv #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [NPIN-1:0] od,
  input  logic [NPIN-1:0] val,
  output logic [NPIN-1:0] pin_o,
  output logic [NPIN-1:0] pin_oe
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_o[i]  <= 1'b0;
        pin_oe[i] <= 1'b0;
      end else if (!en) begin
        pin_o[i]  <= 1'b0;
        pin_oe[i] <= 1'b0;
      end else if (od[i]) begin
        pin_o[i]  <= 1'b0;
        pin_oe[i] <= ~val[i];
      end else begin
        pin_o[i]  <= val[i];
        pin_oe[i] <= 1'b1;
      end
    end

    assert_od_never_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && od[i]) |=> !pin_o[i]);
    assert_pp_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !od[i]) |=> pin_oe[i]);
  end

  assert_off_undriven_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pin_oe == '0));
endmodule

// File: rtl/isp_status_guard.sv
module isp_status_guard
  import isp_pkg::*;
#(
  parameter int NSECT = 8,
  localparam int SW = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_code,
  input  logic [SW-1:0]    cmd_sector,
  input  logic [1:0]       cmd_od,
  input  logic             sec_cfg,
  input  logic [NSECT-1:0] sect_prot,
  input  logic             eng_busy,
  input  logic             eng_fail,
  input  logic             sec_wr_busy,
  input  logic             chip_rst,
  output logic             eng_start,
  output logic [2:0]       eng_op,
  output logic [SW-1:0]    eng_sector,
  output logic             locked,
  output logic             stat_o,
  output logic             stat_oe,
  output logic             err_o,
  output logic             err_oe
);
  logic            isc_en;
  logic [NPIN-1:0] od_mode;
  logic            refuse_c;
  logic            clear_c;
  logic            err_q;
  logic [NPIN-1:0] pin_val;
  logic [NPIN-1:0] pin_o;
  logic [NPIN-1:0] pin_oe;

  isp_cmd_guard #(.NSECT(NSECT)) u_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_sector(cmd_sector), .cmd_od(cmd_od), .sec_cfg(sec_cfg),
    .sect_prot(sect_prot), .isc_en(isc_en), .od_mode(od_mode),
    .locked(locked), .refuse_c(refuse_c), .clear_c(clear_c),
    .eng_start(eng_start), .eng_op(eng_op), .eng_sector(eng_sector)
  );

  isp_err_track u_err (
    .clk(clk), .rst_n(rst_n), .fail(eng_fail | refuse_c), .clr(clear_c),
    .chip_rst(chip_rst), .isc_en(isc_en), .err_q(err_q)
  );

  assign pin_val[PIN_STAT] = ~(eng_busy | sec_wr_busy);
  assign pin_val[PIN_ERR]  = ~err_q;

  isp_pin_drv #(.NPIN(NPIN)) u_pins (
    .clk(clk), .rst_n(rst_n), .en(isc_en), .od(od_mode), .val(pin_val),
    .pin_o(pin_o), .pin_oe(pin_oe)
  );

  assign stat_o  = pin_o[PIN_STAT];
  assign stat_oe = pin_oe[PIN_STAT];
  assign err_o   = pin_o[PIN_ERR];
  assign err_oe  = pin_oe[PIN_ERR];

  assert_refuse_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    refuse_c |=> (err_q && !eng_start));
endmodule

// File: tb/isp_status_guard_test.sv
module isp_status_guard_test;
  localparam int NSECT = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0; logic [2:0] cmd_code = 0; logic [2:0] cmd_sector = 0;
  logic [1:0] cmd_od = 0; logic sec_cfg = 0; logic [7:0] sect_prot = 0;
  logic eng_busy = 0, eng_fail = 0, sec_wr_busy = 0, chip_rst = 0;
  logic eng_start, locked, stat_o, stat_oe, err_o, err_oe;
  logic [2:0] eng_op, eng_sector;
  int nchk = 0, nerr = 0;
  logic st_seen; logic [2:0] op_seen, sec_seen;

  always #10 clk = ~clk;

  isp_status_guard #(.NSECT(NSECT)) uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic chkv(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // expected pin pair {o,oe} computed from enable, open-drain select, value
  function automatic int pin_exp(input bit en, input bit od, input bit v);
    if (!en) return 0;
    if (od) return v ? 0 : 1;
    return v ? 3 : 1;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic issue(input logic [2:0] c, input logic [2:0] s, input logic [1:0] od);
    @(negedge clk); cmd_valid = 1; cmd_code = c; cmd_sector = s; cmd_od = od;
    @(negedge clk); st_seen = eng_start; op_seen = eng_op; sec_seen = eng_sector;
    cmd_valid = 0; cmd_code = 0;
  endtask

  task automatic fail_pulse();
    @(negedge clk); eng_fail = 1; @(negedge clk); eng_fail = 0;
  endtask

  task automatic rst_pulse();
    @(negedge clk); chip_rst = 1; @(negedge clk); chip_rst = 0;
  endtask

  initial begin
    #4_000_000;
    nerr++; nchk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    // R12 reset state
    sec_cfg = 1; do_reset();
    @(negedge clk);
    chkv("R12 locked", locked, 1);
    chkv("R12 stat_oe", stat_oe, 0);
    chkv("R12 err_oe", err_oe, 0);
    chkv("R12 eng_start", eng_start, 0);

    // R1 commands ignored while off
    issue(3'd6, 0, 0); chkv("R1 no start", st_seen, 0);
    @(negedge clk);
    chkv("R1 lock kept", locked, 1);
    chkv("R1 pins off", {stat_oe, err_oe, stat_o, err_o}, 0);
    issue(3'd4, 0, 0); @(negedge clk);
    chkv("R1 no error after ignored cmd", err_oe, 0);

    // R2/R3/R4 pin encoding sweep
    for (int od = 0; od < 4; od++)
      for (int b = 0; b < 3; b++)
        for (int e = 0; e < 2; e++) begin
          sec_cfg = 0; do_reset();
          issue(3'd1, 0, 2'(od));
          if (e != 0) fail_pulse();
          @(negedge clk); eng_busy = (b == 1); sec_wr_busy = (b == 2);
          @(negedge clk); @(negedge clk);
          chkv("R3 R4 status pin", {stat_o, stat_oe}, pin_exp(1, od[0], b == 0));
          chkv("R4 R5 error pin", {err_o, err_oe}, pin_exp(1, od[1], e == 0));
          eng_busy = 0; sec_wr_busy = 0;
        end

    // R2 disable turns pins off
    issue(3'd2, 0, 0); @(negedge clk);
    chkv("R2 disabled pins", {stat_oe, err_oe}, 0);

    // R5/R6 sticky then clear
    sec_cfg = 0; do_reset(); issue(3'd1, 0, 0);
    fail_pulse(); repeat (5) @(negedge clk);
    chkv("R5 sticky low", {err_o, err_oe}, 1);
    issue(3'd3, 0, 0); @(negedge clk);
    chkv("R6 clear releases", {err_o, err_oe}, 3);
    // R5 fail wins over clear in same cycle
    @(negedge clk); eng_fail = 1; cmd_valid = 1; cmd_code = 3'd3;
    @(negedge clk); eng_fail = 0; cmd_valid = 0; @(negedge clk);
    chkv("R5 fail beats clear", {err_o, err_oe}, 1);

    // R7 reset while enabled: no effect
    rst_pulse(); @(negedge clk);
    chkv("R7 reset while on ignored", {err_o, err_oe}, 1);
    // R7 disable, no reset, re-enable: still low
    issue(3'd2, 0, 0); issue(3'd1, 0, 0); @(negedge clk);
    chkv("R7 no reset keeps error", {err_o, err_oe}, 1);
    // R7 disable, reset, re-enable: released
    issue(3'd2, 0, 0); rst_pulse(); issue(3'd1, 0, 0); @(negedge clk);
    chkv("R7 reset after disable releases", {err_o, err_oe}, 3);

    // R8 R9 R10 R11 sweep
    for (int lk = 0; lk < 2; lk++)
      for (int pp = 0; pp < 2; pp++)
        for (int c = 4; c < 8; c++)
          for (int s = 0; s < NSECT; s++) begin
            logic [7:0] pr; bit go;
            pr = (pp != 0) ? 8'hA5 : 8'h3C;
            sec_cfg = 1'(lk); sect_prot = pr; do_reset();
            issue(3'd1, 0, 0);
            issue(3'(c), 3'(s), 0);
            go = !(lk != 0 && c != 6) && !(c == 5 && pr[s]);
            chkv("R8 R10 R11 start", st_seen, go);
            if (go) begin
              chkv("R11 op", op_seen, c);
              chkv("R11 sector", sec_seen, s);
            end
            @(negedge clk);
            chkv("R8 R10 error pin", err_o, go);
            chkv("R11 single pulse", eng_start, 0);
            chkv("R9 lock", locked, (c == 6) ? 0 : lk);
          end

    // R9 after unlock a program is accepted
    sec_cfg = 1; do_reset(); issue(3'd1, 0, 0); issue(3'd6, 0, 0);
    issue(3'd4, 3'd2, 0); chkv("R9 program after unlock", st_seen, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule